// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block guards the system bus against cycles that never complete. Each bus cycle is announced by a one-clock start strobe. From that clock the monitor counts. If no acknowledge arrives within the programmed number of clocks, the monitor pulses a bus-error output for one clock and then goes idle until the next start. A 2-bit code selects the limit, which is 8, 16, 32 or 64 clocks. An enable bit can switch the monitor off.

The code and the enables are held in a protection byte that software may write only once after reset. The same byte carries a halt-monitor enable. With that enable set, a halted processor raises a one-clock halt reset request. The request is also recorded as a sticky cause bit in a reset-status byte.

The cycle monitor is a three-state machine: `CYC_IDLE`, `CYC_COUNT` and `CYC_FAULT`.
- `CYC_IDLE` goes to `CYC_COUNT` on a start strobe while the monitor is enabled.
- `CYC_COUNT` returns to `CYC_IDLE` on an acknowledge or when the monitor is disabled.
- `CYC_COUNT` goes to `CYC_FAULT` when the limit is reached without an acknowledge.
- `CYC_FAULT` always returns to `CYC_IDLE` on the next clock.

The protection byte is a two-state machine:
- `CFG_OPEN` goes to `CFG_LOCKED` on the first write.
- `CFG_LOCKED` is left only by reset.

The halt monitor has three states:
- `HLT_RUN` goes to `HLT_REQ` when the processor is halted and halt monitoring is on.
- `HLT_REQ` always goes to `HLT_HOLD`.
- `HLT_HOLD` returns to `HLT_RUN` once the halt indication drops.

Top module: `bus_cycle_monitor`

## Requirements
- R1: After reset, `bus_err` and `halt_rst_req` are low and `rst_status` is 8'h00.
- R2: Protection bits [1:0] select the timeout: 2'b00 gives 64 clocks, 2'b01 gives 32, 2'b10 gives 16 and 2'b11 gives 8. The clock edge that samples `cyc_start` is edge 0. If no acknowledge comes, `bus_err` is high just after edge N, where N is the limit.
- R3: Until the protection byte is written, the monitor is enabled with the 64-clock timeout.
- R4: While protection bit 2 is 0, `bus_err` never rises, whatever `cyc_start` and `cyc_ack` do.
- R5: Only the first protection write after reset takes effect. Every later write leaves the timeout, the bus-monitor enable (bit 2) and the halt-monitor enable (bit 3) unchanged.
- R6: An acknowledge sampled during counting ends the cycle without an error. A later start begins a fresh full-length count.
- R7: An acknowledge sampled on the same edge at which the limit is reached wins, and `bus_err` stays low.
- R8: A timeout produces a `bus_err` pulse exactly one clock long. `bus_err` then stays low until a new start.
- R9: A `cyc_start` sampled while a count is already running is ignored. The error timing still follows the first start.
- R10: With protection bit 3 set, `cpu_halted` high produces a `halt_rst_req` pulse one clock long, starting just after the first edge that samples it. There is no further request until `cpu_halted` has gone low and high again.
- R11: With protection bit 3 clear, `halt_rst_req` stays low.
- R12: A halt reset request sets `rst_status[4]`. The bit stays set until `rst_n` resets the block, and the other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_wr | input | 1 | Write strobe for the protection byte |
| prot_wdata | input | 8 | Protection byte: [1:0] timeout code, [2] bus-monitor enable, [3] halt-monitor enable |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| cyc_ack | input | 1 | Acknowledge that completes the current bus cycle |
| cpu_halted | input | 1 | High while the processor is halted |
| bus_err | output | 1 | One-clock bus-error pulse on timeout |
| halt_rst_req | output | 1 | One-clock halt reset request |
| rst_status | output | 8 | Reset-cause byte; bit 4 marks a halt reset |

## Verification
Each of the four timeout codes is run without any acknowledge. The error edge is checked at every clock, which separates the limits from each other and exposes any off-by-one in the count. Acknowledges are placed well before the limit and exactly on the limit edge, which separates a correct count clear from an error that wins the race. Overlapping start strobes, a disabled monitor and a second protection write each show a change in error timing or presence that would reveal a wrong restart, a leaking enable or a rewritable byte. The halt input is held, released and raised again, with halt monitoring on and off, which distinguishes a level-triggered request from a one-shot request and a sticky cause bit from a transient one.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
    localparam int PROT_W         = 8;
    localparam int TMO_LSB        = 0;
    localparam int TMO_W          = 2;
    localparam int BME_BIT        = 2;
    localparam int HME_BIT        = 3;
    localparam int STATUS_W       = 8;
    localparam int HALT_CAUSE_BIT = 4;

    // bus monitor on, 64-clock code, halt monitor off
    localparam logic [PROT_W-1:0] PROT_RESET = 8'h04;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_COUNT = 2'd1,
        CYC_FAULT = 2'd2
    } cyc_state_e;

    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_e;

    typedef enum logic [1:0] {
        HLT_RUN  = 2'd0,
        HLT_REQ  = 2'd1,
        HLT_HOLD = 2'd2
    } hlt_state_e;
endpackage

// File: rtl/bcm_prot_reg.sv
module bcm_prot_reg
    import bcm_pkg::*;
#(
    parameter int                 W         = PROT_W,
    parameter logic [PROT_W-1:0]  RESET_VAL = PROT_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cfg_q,
    output logic         locked
);
    cfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN:   if (wr) state_d = CFG_LOCKED;
            CFG_LOCKED: state_d = CFG_LOCKED;
            default:    state_d = CFG_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cfg_q <= RESET_VAL[W-1:0];
        else if (state_q == CFG_OPEN && wr)  cfg_q <= wdata;
    end

    always_comb locked = (state_q == CFG_LOCKED);

    // R5
    write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cfg_q));
endmodule

// File: rtl/bcm_cycle_fsm.sv
module bcm_cycle_fsm
    import bcm_pkg::*;
#(
    parameter int BASE_TIMEOUT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [TMO_W-1:0] code,
    input  logic             start,
    input  logic             ack,
    output logic             bus_err
);
    localparam int CNT_W = $clog2(BASE_TIMEOUT + 1);

    cyc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             at_limit;

    always_comb limit = CNT_W'(BASE_TIMEOUT >> code);
    always_comb at_limit = (cnt_q == limit - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE:  if (en && start) state_d = CYC_COUNT;
            CYC_COUNT: begin
                if (!en || ack)    state_d = CYC_IDLE;
                else if (at_limit) state_d = CYC_FAULT;
            end
            CYC_FAULT: state_d = CYC_IDLE;
            default:   state_d = CYC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CYC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (state_q != CYC_COUNT) cnt_q <= '0;
        else                          cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb bus_err = (state_q == CYC_FAULT);

    // R7
    ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !bus_err);
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);
    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en) && $past(!en, 2)) |-> !bus_err);
endmodule

// File: rtl/bcm_halt_mon.sv
module bcm_halt_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic halted,
    output logic req,
    output logic cause_seen
);
    import bcm_pkg::*;

    hlt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HLT_RUN:  if (en && halted) state_d = HLT_REQ;
            HLT_REQ:  state_d = HLT_HOLD;
            HLT_HOLD: if (!halted) state_d = HLT_RUN;
            default:  state_d = HLT_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HLT_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cause_seen <= 1'b0;
        else if (state_d == HLT_REQ) cause_seen <= 1'b1;
    end

    always_comb req = (state_q == HLT_REQ);

    // R10
    halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    // R12
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cause_seen) |-> cause_seen);
    // R12
    cause_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> cause_seen);
endmodule

// File: rtl/bus_cycle_monitor.sv
module bus_cycle_monitor
    import bcm_pkg::*;
#(
    parameter int BASE_TIMEOUT = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prot_wr,
    input  logic [PROT_W-1:0]   prot_wdata,
    input  logic                cyc_start,
    input  logic                cyc_ack,
    input  logic                cpu_halted,
    output logic                bus_err,
    output logic                halt_rst_req,
    output logic [STATUS_W-1:0] rst_status
);
    logic [PROT_W-1:0] cfg;
    logic              cfg_locked;
    logic              halt_seen;

    bcm_prot_reg u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (prot_wr),
        .wdata  (prot_wdata),
        .cfg_q  (cfg),
        .locked (cfg_locked)
    );

    bcm_cycle_fsm #(.BASE_TIMEOUT(BASE_TIMEOUT)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg[BME_BIT]),
        .code    (cfg[TMO_LSB +: TMO_W]),
        .start   (cyc_start),
        .ack     (cyc_ack),
        .bus_err (bus_err)
    );

    bcm_halt_mon u_halt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg[HME_BIT]),
        .halted     (cpu_halted),
        .req        (halt_rst_req),
        .cause_seen (halt_seen)
    );

    always_comb begin
        rst_status                 = '0;
        rst_status[HALT_CAUSE_BIT] = halt_seen;
    end

    // R11
    halt_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_rst_req |-> cfg[HME_BIT]);
    // R5
    lock_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_locked) |-> cfg_locked);
endmodule

// File: tb/bus_cycle_monitor_test.sv
module bus_cycle_monitor_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prot_wr = 1'b0;
    logic [7:0] prot_wdata = 8'h00;
    logic       cyc_start = 1'b0;
    logic       cyc_ack = 1'b0;
    logic       cpu_halted = 1'b0;
    logic       bus_err;
    logic       halt_rst_req;
    logic [7:0] rst_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_monitor uut (
        .clk(clk), .rst_n(rst_n), .prot_wr(prot_wr), .prot_wdata(prot_wdata),
        .cyc_start(cyc_start), .cyc_ack(cyc_ack), .cpu_halted(cpu_halted),
        .bus_err(bus_err), .halt_rst_req(halt_rst_req), .rst_status(rst_status)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; prot_wr = 0; cyc_start = 0; cyc_ack = 0; cpu_halted = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_prot(logic [7:0] v);
        prot_wr = 1'b1; prot_wdata = v;
        @(negedge clk);
        prot_wr = 1'b0;
        @(negedge clk);
    endtask

    // leaves us at the negedge just after edge 0
    task automatic start_pulse();
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    // error must rise just after edge 'lim', last one clock
    task automatic expect_timeout(string tag, int lim);
        bit ok = 1'b1;
        for (int k = 1; k <= lim + 3; k++) begin
            @(negedge clk);
            if (bus_err !== (k == lim)) begin
                ok = 1'b0;
                $display("FAIL %s: bus_err=%b expected %b after edge %0d (limit %0d)",
                         tag, bus_err, (k == lim), k, lim);
            end
        end
        checks++;
        if (!ok) fails++;
    endtask

    task automatic expect_quiet(string tag, int n);
        bit ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (bus_err !== 1'b0) ok = 1'b0;
        end
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual bus_err 1 expected 0 within %0d clocks", tag, n);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 bus_err", {7'd0, bus_err}, 8'h00);
        chk("R1 halt_rst_req", {7'd0, halt_rst_req}, 8'h00);
        chk("R1 rst_status", rst_status, 8'h00);
    endtask

    task automatic t_default();
        do_reset();
        start_pulse();
        expect_timeout("R3 default 64", 64);
    endtask

    task automatic t_codes();
        do_reset(); write_prot(8'h07); start_pulse(); expect_timeout("R2 code11", 8);
        do_reset(); write_prot(8'h06); start_pulse(); expect_timeout("R2 code10", 16);
        do_reset(); write_prot(8'h05); start_pulse(); expect_timeout("R2 code01", 32);
        do_reset(); write_prot(8'h04); start_pulse(); expect_timeout("R2 code00", 64);
    endtask

    task automatic t_disabled();
        do_reset();
        write_prot(8'h03);
        start_pulse();
        expect_quiet("R4 disabled", 80);
        cyc_ack = 1'b1; start_pulse(); cyc_ack = 1'b0;
        expect_quiet("R4 disabled again", 20);
    endtask

    task automatic t_write_once();
        do_reset();
        write_prot(8'h07);
        write_prot(8'h00);
        start_pulse();
        expect_timeout("R5 second write ignored", 8);
        write_prot(8'h08);
        cpu_halted = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 hme not set by late write", {7'd0, halt_rst_req}, 8'h00);
        cpu_halted = 1'b0;
    endtask

    task automatic t_ack_early();
        do_reset();
        write_prot(8'h06);
        start_pulse();
        repeat (4) @(negedge clk);
        cyc_ack = 1'b1; @(negedge clk); cyc_ack = 1'b0;
        expect_quiet("R6 ack clears", 30);
        start_pulse();
        expect_timeout("R6 fresh count", 16);
    endtask

    task automatic t_ack_race();
        do_reset();
        write_prot(8'h07);
        start_pulse();
        repeat (7) @(negedge clk);
        cyc_ack = 1'b1;
        @(negedge clk);
        cyc_ack = 1'b0;
        chk("R7 ack on limit edge", {7'd0, bus_err}, 8'h00);
        expect_quiet("R7 no late error", 12);
    endtask

    task automatic t_single_pulse();
        do_reset();
        write_prot(8'h07);
        start_pulse();
        expect_timeout("R8 one clock", 8);
        expect_quiet("R8 stays low", 20);
    endtask

    task automatic t_restart_ignored();
        do_reset();
        write_prot(8'h06);
        start_pulse();
        repeat (4) @(negedge clk);
        start_pulse();
        expect_timeout("R9 second start ignored", 16 - 5);
    endtask

    task automatic t_halt_on();
        do_reset();
        write_prot(8'h0C);
        cpu_halted = 1'b1;
        @(negedge clk);
        chk("R10 request", {7'd0, halt_rst_req}, 8'h01);
        chk("R12 cause set", rst_status, 8'h10);
        @(negedge clk);
        chk("R10 one clock", {7'd0, halt_rst_req}, 8'h00);
        repeat (5) @(negedge clk);
        chk("R10 no repeat while held", {7'd0, halt_rst_req}, 8'h00);
        cpu_halted = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 cause sticky", rst_status, 8'h10);
        cpu_halted = 1'b1;
        @(negedge clk);
        chk("R10 request again", {7'd0, halt_rst_req}, 8'h01);
        cpu_halted = 1'b0;
        do_reset();
        chk("R12 cleared by reset", rst_status, 8'h00);
    endtask

    task automatic t_halt_off();
        bit seen = 1'b0;
        do_reset();
        write_prot(8'h04);
        cpu_halted = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (halt_rst_req) seen = 1'b1;
        end
        cpu_halted = 1'b0;
        chk("R11 no request", {7'd0, seen}, 8'h00);
        chk("R11 status clear", rst_status, 8'h00);
    endtask

    initial begin
        t_reset_state();
        t_default();
        t_codes();
        t_disabled();
        t_write_once();
        t_ack_early();
        t_ack_race();
        t_single_pulse();
        t_restart_ignored();
        t_halt_on();
        t_halt_off();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule